// File: doc/BRIEF.md
# Tick-Driven Motion Delay Timer

This block times open-loop robot movements. The motors run at a fixed speed, so distance and turn angle follow from elapsed time. The time base is a slow square wave from an external oscillator, nominally 128 Hz, which arrives at a core clocked at 4 MHz. The block resynchronises that wave, keeps a two-sample history of it, and turns each low-to-high transition into a strobe one system clock wide. Each strobe advances an 8-bit prescaler. When the prescaler reaches its all-ones value, 255 strobes or about two seconds, the short delay is complete.

Each time the prescaler wraps, it advances a 4-bit extension counter. Each bit of that counter marks a longer delay, and each delay is twice the one before it. A behaviour that takes over the motors asserts a restart strobe. The strobe returns the whole delay chain to zero and clears all the completion flags, so timing starts again from that moment.

Top module: `motion_delay_timer`

## Requirements
- R1: The external tick passes through a two-flop synchronizer and then a two-sample history register before it is used. A tick that stays high for many system clocks counts as one event.
- R2: A strobe fires for exactly one system clock when the newer history sample is 1 and the older one is 0. Falling edges and steady levels produce no strobe.
- R3: The prescaler advances by one on each strobe and holds its value otherwise. `short_done` goes to 1 on the strobe that brings the prescaler to 255, and not before.
- R4: A restart pulse returns the prescaler, the extension counter, `short_done` and every `long_done` bit to 0 at the next clock edge.
- R5: Once set, `short_done` stays at 1 until a restart or reset, including after the prescaler wraps from 255 to 0.
- R6: The extension counter advances exactly when a strobe arrives while the prescaler holds 255, so it advances once per 256 strobes.
- R7: `long_done[i]` becomes 1 on the strobe that first sets bit i of the extension counter. That strobe is the 256·2^i-th after a restart: bit 0 after 256, bit 1 after 512, bit 2 after 1024, bit 3 after 2048. Each flag then stays at 1 until a restart or reset, even after the extension counter wraps to 0 at 4096 strobes.
- R8: When a restart and a strobe fall in the same cycle, the restart wins. The counters end at 0, and a full 255 further strobes are needed to set `short_done`.
- R9: While synchronous active-high `rst` is asserted, and in the cycle after it, `short_done` and all `long_done` bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Slow external square-wave tick, asynchronous to clk |
| restart | input | 1 | Restart strobe; clears the delay chain and all flags |
| short_done | output | 1 | Sticky flag: 255 strobes counted since the last restart |
| long_done | output | 4 | Sticky flags: bit i set after 256·2^i strobes |

## Verification
The hardest case to reach from the ports is a restart that lands in exactly the cycle the strobe is live. That cycle sits four clock edges after the tick rises, behind the synchronizer and the history register. The stimulus drives the tick high just after an edge, counts three rising edges, and then holds restart for a single cycle. The bench then applies 254 ticks and expects `short_done` to stay low, then one more and expects it high. That sequence shows the colliding strobe was discarded rather than counted. A second hard region is the far end of the extension ladder. There the bench runs the tick for more than 4096 events to see each long flag appear at its own count and survive the wrap of the extension counter.

// File: rtl/mdt_pkg.sv
package mdt_pkg;

    localparam int PRE_W_DEFAULT  = 8;
    localparam int EXT_W_DEFAULT  = 4;
    localparam int SYNC_N_DEFAULT = 2;

    // Two-sample history of the synchronized tick.
    typedef struct packed {
        logic newest;
        logic older;
    } tick_hist_t;

    function automatic logic hist_rise(input tick_hist_t h);
        return h.newest & ~h.older;
    endfunction

    function automatic tick_hist_t hist_shift(input tick_hist_t h, input logic sample);
        tick_hist_t n;
        n.newest = sample;
        n.older  = h.newest;
        return n;
    endfunction

endpackage

// File: rtl/mdt_edge_pulse.sv
module mdt_edge_pulse
    import mdt_pkg::*;
#(
    parameter int SYNC_N = SYNC_N_DEFAULT
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_in,
    output logic pulse_o
);

    logic [SYNC_N-1:0] sync_q;
    tick_hist_t        hist_q;

    generate
        if (SYNC_N == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= tick_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_N-2:0], tick_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= hist_shift(hist_q, sync_q[SYNC_N-1]);
    end

    assign pulse_o = hist_rise(hist_q);

endmodule

// File: rtl/mdt_prescaler.sv
module mdt_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         step,
    output logic [W-1:0] cnt_o,
    output logic         carry_o,
    output logic         done_o
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_q;
    logic         done_q;
    logic         at_top;

    assign at_top  = (cnt_q == TOP);
    assign carry_o = step & at_top & ~clear;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            if (step) cnt_q <= cnt_q + 1'b1;
            if (step && cnt_q == TOP - 1'b1) done_q <= 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign done_o = done_q;

endmodule

// File: rtl/mdt_extender.sv
module mdt_extender #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         step,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] flags_o
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_nx;
    logic [W-1:0] flag_q;

    assign cnt_nx = step ? cnt_q + 1'b1 : cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) cnt_q <= '0;
        else              cnt_q <= cnt_nx;
    end

    generate
        for (genvar i = 0; i < W; i++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst || clear)   flag_q[i] <= 1'b0;
                else if (cnt_nx[i]) flag_q[i] <= 1'b1;
            end
        end
    endgenerate

    assign cnt_o   = cnt_q;
    assign flags_o = flag_q;

endmodule

// File: rtl/motion_delay_timer.sv
module motion_delay_timer
    import mdt_pkg::*;
#(
    parameter int PRE_W  = PRE_W_DEFAULT,
    parameter int EXT_W  = EXT_W_DEFAULT,
    parameter int SYNC_N = SYNC_N_DEFAULT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_in,
    input  logic             restart,
    output logic             short_done,
    output logic [EXT_W-1:0] long_done
);

    logic             tick_pulse;
    logic             pre_carry;
    logic [PRE_W-1:0] pre_cnt;
    logic [EXT_W-1:0] ext_cnt;

    mdt_edge_pulse #(.SYNC_N(SYNC_N)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .tick_in (tick_in),
        .pulse_o (tick_pulse)
    );

    mdt_prescaler #(.W(PRE_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .clear   (restart),
        .step    (tick_pulse),
        .cnt_o   (pre_cnt),
        .carry_o (pre_carry),
        .done_o  (short_done)
    );

    mdt_extender #(.W(EXT_W)) u_ext (
        .clk     (clk),
        .rst     (rst),
        .clear   (restart),
        .step    (pre_carry),
        .cnt_o   (ext_cnt),
        .flags_o (long_done)
    );

endmodule

// File: rtl/mdt_checker.sv
module mdt_checker #(
    parameter int PRE_W = 8,
    parameter int EXT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             restart,
    input logic             pulse,
    input logic [PRE_W-1:0] pre_cnt,
    input logic [EXT_W-1:0] ext_cnt,
    input logic             short_done,
    input logic [EXT_W-1:0] long_done
);

    localparam logic [PRE_W-1:0] TOP = {PRE_W{1'b1}};

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse); // R2

    AST_PRE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!pulse && !restart) |=> $stable(pre_cnt)); // R3

    AST_PRE_STEP: assert property (@(posedge clk) disable iff (rst)
        (pulse && !restart) |=> pre_cnt == PRE_W'($past(pre_cnt) + 1'b1)); // R3

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
        restart |=> (pre_cnt == '0 && ext_cnt == '0 && !short_done && long_done == '0)); // R4

    AST_SHORT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (short_done && !restart) |=> short_done); // R5

    AST_EXT_STEP: assert property (@(posedge clk) disable iff (rst)
        (pulse && pre_cnt == TOP && !restart) |=> ext_cnt == EXT_W'($past(ext_cnt) + 1'b1)); // R6

    AST_LONG_STICKY: assert property (@(posedge clk) disable iff (rst)
        !restart |=> ((long_done & $past(long_done)) == $past(long_done))); // R7

    AST_COLLIDE_RESTART: assert property (@(posedge clk) disable iff (rst)
        (pulse && restart) |=> pre_cnt == '0); // R8

endmodule

bind motion_delay_timer mdt_checker #(.PRE_W(PRE_W), .EXT_W(EXT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .restart    (restart),
    .pulse      (tick_pulse),
    .pre_cnt    (pre_cnt),
    .ext_cnt    (ext_cnt),
    .short_done (short_done),
    .long_done  (long_done)
);

// File: tb/motion_delay_timer_bench.sv
module motion_delay_timer_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_in = 1'b0;
    logic       restart = 1'b0;
    logic       short_done;
    logic [3:0] long_done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    motion_delay_timer u_motion_delay_timer (
        .clk        (clk),
        .rst        (rst),
        .tick_in    (tick_in),
        .restart    (restart),
        .short_done (short_done),
        .long_done  (long_done)
    );

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // One tick: rises after a negedge, high 3 cycles, low 3 cycles.
    task automatic send_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_in = 1'b1;
            repeat (3) @(negedge clk);
            tick_in = 1'b0;
            repeat (2) @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic do_restart;
        @(negedge clk); restart = 1'b1;
        @(negedge clk); restart = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R9 in reset", {short_done, long_done}, 5'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R9 after reset", {short_done, long_done}, 5'b0);
    endtask

    task automatic t_short;
        do_restart();
        send_ticks(254);
        check("R3 at 254", {short_done, long_done}, 5'b0_0000);
        send_ticks(1);
        check("R3 at 255", {short_done, long_done}, 5'b1_0000);
        send_ticks(1);
        check("R5 after prescaler wrap", {4'b0, short_done}, 5'b1);
        check("R6 first wrap", {1'b0, long_done}, 5'b0_0001);
    endtask

    task automatic t_restart_clears;
        do_restart();
        check("R4 flags cleared", {short_done, long_done}, 5'b0);
        send_ticks(254);
        check("R4 count restarted", {short_done, long_done}, 5'b0);
    endtask

    task automatic t_level;
        do_restart();
        send_ticks(253);
        @(negedge clk); tick_in = 1'b1;
        repeat (30) @(negedge clk);
        tick_in = 1'b0;
        repeat (30) @(negedge clk);
        check("R1 long high counts once", {4'b0, short_done}, 5'b0);
        send_ticks(1);
        check("R2 one strobe per rise", {4'b0, short_done}, 5'b1);
    endtask

    task automatic t_collision;
        do_restart();
        send_ticks(10);
        @(negedge clk); tick_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); restart = 1'b1;
        @(negedge clk); restart = 1'b0;
        tick_in = 1'b0;
        repeat (4) @(negedge clk);
        send_ticks(254);
        check("R8 restart wins, 254", {4'b0, short_done}, 5'b0);
        send_ticks(1);
        check("R8 restart wins, 255", {4'b0, short_done}, 5'b1);
    endtask

    task automatic t_long;
        do_restart();
        send_ticks(511);
        check("R7 at 511", {1'b0, long_done}, 5'b0_0001);
        send_ticks(1);
        check("R7 at 512", {1'b0, long_done}, 5'b0_0011);
        send_ticks(512);
        check("R7 at 1024", {1'b0, long_done}, 5'b0_0111);
        send_ticks(1023);
        check("R7 at 2047", {1'b0, long_done}, 5'b0_0111);
        send_ticks(1);
        check("R7 at 2048", {1'b0, long_done}, 5'b0_1111);
        send_ticks(2048);
        check("R7 sticky after wrap", {short_done, long_done}, 5'b1_1111);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_short();
        t_restart_clears();
        t_level();
        t_collision();
        t_long();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule